// File: doc/BRIEF.md
# Data-Enable Raster Timing Generator for an 18-bit TFT Panel

This block drives an 18-bit parallel TFT panel that has no separate horizontal or vertical sync pins and instead recovers all of its line and frame timing from one data-enable signal. It runs from a free-running pixel clock, walks a fixed raster of 860 clocks per line and 615 lines per frame (800 by 600 visible), and raises the enable only for visible pixels. Because the panel decodes its internal drive from the enable edges, every line and every frame carries exactly the same blanking length.

In step with the raster, the block issues a read strobe and a linear read address to a frame-buffer port with one cycle of read latency, takes the returned colour word (6 bits each of red, green and blue) and registers it to the panel together with the enable. Two frame buffers are supported; a swap request is taken only on the final clock of a frame, so the displayed buffer changes only between frames and the raster is never disturbed.

Top module: `tft_de_timing`

## Requirements
- R1: While `rst` is high, `de_o` is 0, `pix_o` is 0, `rd_en_o` is 0 and `buf_sel_o` is 0; the raster position is held at line 0, pixel 0.
- R2: Each line lasts exactly H_TOTAL (860) clocks, and within a visible line `de_o` is high for exactly H_ACTIVE (800) consecutive clocks.
- R3: Each frame lasts exactly V_TOTAL (615) lines; `de_o` stays low for all of lines V_ACTIVE (600) to V_TOTAL-1.
- R4: Every low interval of `de_o` after the first rise is either H_TOTAL-H_ACTIVE clocks (inside a frame) or (V_TOTAL-V_ACTIVE)*H_TOTAL + H_TOTAL-H_ACTIVE clocks (across a frame boundary), never anything else.
- R5: `rd_en_o` is high exactly for visible raster positions and leads `de_o` for the same pixel by two clocks.
- R6: The read address of the pixel at line v, pixel h is base + v*H_ACTIVE + h, where base is BASE0 when `buf_sel_o` is 0 and BASE1 when it is 1; addresses rise by one per read.
- R7: Whenever `de_o` is high, `pix_o` equals the word presented on `rd_data_i` one clock after the matching `rd_en_o`; whenever `de_o` is low, `pix_o` is 0.
- R8: `buf_sel_o` toggles only on the clock edge that ends the last pixel of line V_TOTAL-1, and only if `swap_req_i` is 1 during that last clock; otherwise it holds.
- R9: After `rst` falls, the raster starts at line 0, pixel 0 in the first cycle, the first read strobe appears after the first clock edge and the first `de_o` high after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| swap_req_i | input | 1 | Request to flip the displayed buffer at the next frame end |
| rd_data_i | input | 18 | Colour word from the frame buffer, valid one clock after the strobe |
| rd_en_o | output | 1 | Frame-buffer read strobe |
| rd_addr_o | output | 20 | Frame-buffer read address |
| de_o | output | 1 | Panel data enable |
| pix_o | output | 18 | Panel colour word, 6 bits each of red, green, blue |
| buf_sel_o | output | 1 | Buffer currently being scanned out |

## Verification
The assertions assume the frame-buffer port really has one clock of read latency, so the word on `rd_data_i` in the cycle after a strobe belongs to that strobe; the bench models the memory as a register loaded from the address on each strobe and drives random junk on other cycles so that a leak into `pix_o` during blanking shows. They also assume the swap request may change in any cycle; the bench randomises it every clock on a reduced-geometry instance so that many frame ends see both values, while the full-size instance is checked over its first lines with the request held low.

// File: rtl/tft_pkg.sv
package tft_pkg;
    // default panel geometry
    localparam int DEF_H_ACTIVE = 800;
    localparam int DEF_H_TOTAL  = 860;
    localparam int DEF_V_ACTIVE = 600;
    localparam int DEF_V_TOTAL  = 615;
    localparam int DEF_PIX_W    = 18;
    localparam int DEF_ADDR_W   = 20;

    // scan-out buffer choice
    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;
endpackage

// File: rtl/tft_raster_cnt.sv
module tft_raster_cnt #(
    parameter int H_ACTIVE = tft_pkg::DEF_H_ACTIVE,
    parameter int H_TOTAL  = tft_pkg::DEF_H_TOTAL,
    parameter int V_ACTIVE = tft_pkg::DEF_V_ACTIVE,
    parameter int V_TOTAL  = tft_pkg::DEF_V_TOTAL
) (
    input  logic clk,
    input  logic rst,
    output logic active_o,
    output logic frame_last_o
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t r_d, r_q;
    logic line_end;

    always_comb begin
        r_d      = r_q;
        line_end = (r_q.h == H_LAST);
        if (line_end) begin
            r_d.h = '0;
            r_d.v = (r_q.v == V_LAST) ? '0 : r_q.v + VW'(1);
        end else begin
            r_d.h = r_q.h + HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign active_o     = (r_q.h < HW'(H_ACTIVE)) && (r_q.v < VW'(V_ACTIVE));
    assign frame_last_o = line_end && (r_q.v == V_LAST);

    assert_h_range_R2: assert property (@(posedge clk) disable iff (rst)
        r_q.h <= H_LAST);
    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (r_q.h == H_LAST) |=> (r_q.h == '0));
    assert_v_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.h != H_LAST) |=> $stable(r_q.v));
    assert_v_range_R3: assert property (@(posedge clk) disable iff (rst)
        r_q.v <= V_LAST);
endmodule

// File: rtl/tft_fetch.sv
module tft_fetch #(
    parameter int ADDR_W = tft_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] BASE0 = '0,
    parameter logic [ADDR_W-1:0] BASE1 = ADDR_W'(480000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              frame_last_i,
    input  logic              swap_req_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              buf_sel_o
);
    import tft_pkg::*;

    typedef struct packed {
        buf_sel_e          sel;
        logic [ADDR_W-1:0] ptr;
        logic              rd_en;
        logic [ADDR_W-1:0] addr;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.rd_en = active_i;
        if (active_i) begin
            f_d.addr = f_q.ptr;
            f_d.ptr  = f_q.ptr + ADDR_W'(1);
        end
        if (frame_last_i) begin
            if (swap_req_i) f_d.sel = (f_q.sel == BUF_A) ? BUF_B : BUF_A;
            f_d.ptr = (f_d.sel == BUF_B) ? BASE1 : BASE0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q.sel   <= BUF_A;
            f_q.ptr   <= BASE0;
            f_q.rd_en <= 1'b0;
            f_q.addr  <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_en_o   = f_q.rd_en;
    assign rd_addr_o = f_q.addr;
    assign buf_sel_o = f_q.sel;

    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_last_i |=> $stable(f_q.sel));
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (f_q.rd_en && $past(f_q.rd_en)) |-> (f_q.addr == $past(f_q.addr) + ADDR_W'(1)));
endmodule

// File: rtl/tft_out_stage.sv
module tft_out_stage #(
    parameter int PIX_W = tft_pkg::DEF_PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_i,
    input  logic [PIX_W-1:0] rd_data_i,
    output logic             de_o,
    output logic [PIX_W-1:0] pix_o
);
    typedef struct packed {
        logic             vld;
        logic             de;
        logic [PIX_W-1:0] pix;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.vld = rd_en_i;
        o_d.de  = o_q.vld;
        o_d.pix = o_q.vld ? rd_data_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign de_o  = o_q.de;
    assign pix_o = o_q.pix;

    assert_pix_path_R7: assert property (@(posedge clk) disable iff (rst)
        o_q.de |-> (o_q.pix == $past(rd_data_i)));
endmodule

// File: rtl/tft_de_timing.sv
module tft_de_timing #(
    parameter int H_ACTIVE = tft_pkg::DEF_H_ACTIVE,
    parameter int H_TOTAL  = tft_pkg::DEF_H_TOTAL,
    parameter int V_ACTIVE = tft_pkg::DEF_V_ACTIVE,
    parameter int V_TOTAL  = tft_pkg::DEF_V_TOTAL,
    parameter int PIX_W    = tft_pkg::DEF_PIX_W,
    parameter int ADDR_W   = tft_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] BASE0 = '0,
    parameter logic [ADDR_W-1:0] BASE1 = ADDR_W'(H_ACTIVE * V_ACTIVE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              swap_req_i,
    input  logic [PIX_W-1:0]  rd_data_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              de_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic              buf_sel_o
);
    logic active, frame_last;

    tft_raster_cnt #(
        .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
        .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL)
    ) u_raster (
        .clk(clk), .rst(rst),
        .active_o(active), .frame_last_o(frame_last)
    );

    tft_fetch #(
        .ADDR_W(ADDR_W), .BASE0(BASE0), .BASE1(BASE1)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .active_i(active), .frame_last_i(frame_last), .swap_req_i(swap_req_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .buf_sel_o(buf_sel_o)
    );

    tft_out_stage #(
        .PIX_W(PIX_W)
    ) u_out (
        .clk(clk), .rst(rst),
        .rd_en_i(rd_en_o), .rd_data_i(rd_data_i),
        .de_o(de_o), .pix_o(pix_o)
    );

    assert_de_lag_R5: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> ##2 de_o);
    assert_blank_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !de_o |-> (pix_o == '0));
endmodule

// File: tb/sim_tft_de_timing.sv
module sim_tft_de_timing;
    localparam int PERIOD = 10;
    localparam int RUN    = 120000;
    // reduced geometry for u1
    localparam int SHA = 6, SHT = 9, SVA = 4, SVT = 6;
    localparam int SF  = SHT * SVT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // full-size instance
    logic        sw0 = 1'b0;
    logic [17:0] rd0;
    logic        en0, de0, bs0;
    logic [19:0] ad0;
    logic [17:0] px0;
    // reduced instance
    logic        sw1 = 1'b0;
    logic [17:0] rd1;
    logic        en1, de1, bs1;
    logic [7:0]  ad1;
    logic [17:0] px1;

    tft_de_timing u0 (
        .clk(clk), .rst(rst), .swap_req_i(sw0), .rd_data_i(rd0),
        .rd_en_o(en0), .rd_addr_o(ad0), .de_o(de0), .pix_o(px0), .buf_sel_o(bs0)
    );

    tft_de_timing #(
        .H_ACTIVE(SHA), .H_TOTAL(SHT), .V_ACTIVE(SVA), .V_TOTAL(SVT),
        .ADDR_W(8), .BASE0(8'd3), .BASE1(8'd100)
    ) u1 (
        .clk(clk), .rst(rst), .swap_req_i(sw1), .rd_data_i(rd1),
        .rd_en_o(en1), .rd_addr_o(ad1), .de_o(de1), .pix_o(px1), .buf_sel_o(bs1)
    );

    function automatic int pat(int a);
        return (a * 40503 + 5) & 32'h3ffff;
    endfunction

    // frame-buffer models with one clock read latency, junk otherwise
    always @(posedge clk) begin
        rd0 <= en0 ? 18'(pat(int'(ad0))) : 18'($urandom);
        rd1 <= en1 ? 18'(pat(int'(ad1))) : 18'($urandom);
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle model check; n = clock edges since reset release
    task automatic chk_inst(int n, int ha, int ht, int va, int vt, int b0, int b1,
                            int sel_p1, int sel_p3, int sel_n,
                            logic en, int ad, logic de, int px, logic bs);
        int p1 = n - 1;
        int p3 = n - 3;
        bit e_en = 0, e_de = 0;
        int e_ad = 0, e_px = 0, h, v;
        if (p1 >= 0) begin
            h = p1 % ht; v = (p1 / ht) % vt;
            e_en = (h < ha) && (v < va);
            e_ad = (sel_p1 ? b1 : b0) + v * ha + h;
        end
        if (p3 >= 0) begin
            h = p3 % ht; v = (p3 / ht) % vt;
            e_de = (h < ha) && (v < va);
            if (e_de) e_px = pat((sel_p3 ? b1 : b0) + v * ha + h);
        end
        chk(en == e_en, "R5 read strobe", int'(en), int'(e_en));
        if (e_en) chk(ad == e_ad, "R6 read address", ad, e_ad);
        chk(de == e_de, "R2/R3 R9 enable", int'(de), int'(e_de));
        chk(px == e_px, "R7 pixel word", px, e_px);
        chk(int'(bs) == sel_n, "R8 buffer select", int'(bs), sel_n);
    endtask

    // enable run-length check
    task automatic chk_runs(logic de, int ha, int ht, int va, int vt,
                            inout bit prev, inout bit seen, inout int run);
        if (de != prev && seen) begin
            if (prev) chk(run == ha, "R2 active run", run, ha);
            else chk(run == ht - ha || run == (vt - va) * ht + ht - ha,
                     "R4 blank run", run, ht - ha);
        end
        if (de && !prev) seen = 1'b1;
        run  = (de != prev) ? 1 : run + 1;
        prev = de;
    endtask

    bit sel1 [0:4095];
    bit pv0 = 0, sn0 = 0, pv1 = 0, sn1 = 0;
    int rn0 = 0, rn1 = 0;

    initial begin
        int n;
        void'($urandom(32'd20240));
        foreach (sel1[i]) sel1[i] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(de0 == 0 && de1 == 0, "R1 enable in reset", int'(de0 | de1), 0);
        chk(px0 == 0 && px1 == 0, "R1 pixel in reset", int'(px0 | px1), 0);
        chk(en0 == 0 && en1 == 0, "R1 strobe in reset", int'(en0 | en1), 0);
        chk(bs0 == 0 && bs1 == 0, "R1 select in reset", int'(bs0 | bs1), 0);
        rst = 1'b0;
        n = 0;
        for (int c = 0; c <= RUN; c++) begin
            if (c > 0) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
            chk_inst(n, 800, 860, 600, 615, 0, 480000, 0, 0, 0,
                     en0, int'(ad0), de0, int'(px0), bs0);
            chk_inst(n, SHA, SHT, SVA, SVT, 3, 100,
                     (n >= 1) ? int'(sel1[(n-1)/SF]) : 0,
                     (n >= 3) ? int'(sel1[(n-3)/SF]) : 0,
                     int'(sel1[n/SF]),
                     en1, int'(ad1), de1, int'(px1), bs1);
            chk_runs(de0, 800, 860, 600, 615, pv0, sn0, rn0);
            chk_runs(de1, SHA, SHT, SVA, SVT, pv1, sn1, rn1);
            // new swap request for position n; force a few directed values
            if ((n / SF) % 7 == 3)      sw1 = 1'b1;
            else if ((n / SF) % 7 == 4) sw1 = 1'b0;
            else                        sw1 = 1'($urandom);
            if (n % SF == SF - 1)
                sel1[n/SF + 1] = sel1[n/SF] ^ sw1;
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule